// File: doc/BRIEF.md
# Video Stream Blanking Filter

This block sits on the receive side of a parallel digital video stream that uses in-band timing references. It takes one sample per clock, up to `DATA_W` bits wide. It finds the four-word timing reference codes in the stream and keeps track of whether the current line is a vertical-blanking line or an active-field line. It also tracks whether the current sample lies in horizontal blanking or in the active picture. From that it decides, sample by sample, whether to hand the sample to a memory-write port that uses a valid/ready handshake.

Three capture modes choose what is kept:

- **Active picture only**: control codes and all blanking are dropped.
- **Vertical-blanking lines only**: each such line is kept whole, including its codes and its horizontal blanking.
- **Everything**: every sample is kept.

The mode and a start delay are both taken at a frame boundary. The delay skips a programmable number of samples at the start of each frame.

The stream cannot be held back. If the write port is not ready when a sample has to go out, the sample is lost and a sticky overflow flag is raised.

Top module: `video_blank_filter`

## Requirements
- R1: While reset is held, and after it until the first frame start is detected, `outValid` is 0. During reset `overflow` is 0.
- R2: A timing reference is four consecutive samples whose low bytes are 0xFF, 0x00, 0x00 and a status word. The upper bits of those samples are ignored. In the status word, bit 6 is the field (F), bit 5 is vertical blanking (V), and bit 4 is 1 for an end-of-active-video code and 0 for a start-of-active-video code (H).
- R3: All four words of a reference take the V and H of their own status word. Every following non-code sample takes the V and H of the most recent reference.
- R4: A frame start is a reference with F=0 and V=1 whose predecessor did not have F=0 and V=1. After reset the predecessor counts as F=1, V=0. `modeSel` and `delayCfg` are sampled only at a frame start.
- R5: With the latched mode 0 or 3, only samples with V=0, H=0 that are not part of a reference are forwarded.
- R6: With the latched mode 1, every sample with V=1 is forwarded, including reference words and horizontal blanking. No sample with V=0 is forwarded.
- R7: With the latched mode 2, every sample is forwarded.
- R8: With a latched delay D, the first D samples of the frame are not forwarded in any mode. The count starts at the first preamble word (0xFF) of the frame-start reference.
- R9: A cycle with `outValid`=1 and `outReady`=0 sets `overflow`. It stays set until a cycle with `ovfClear`=1 in which no new loss occurs. A loss in the same cycle as a clear wins.
- R10: `outReady`=0 during cycles that forward nothing leaves `overflow` unchanged.
- R11: Changing `modeSel` or `delayCfg` in the middle of a frame has no effect before the next frame start.
- R12: Forwarded samples leave in input order, each carrying its full input value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, one input word per cycle |
| rstN | input | 1 | Asynchronous reset, active low |
| pixData | input | DATA_W | Incoming stream sample |
| modeSel | input | 2 | Capture mode: 0/3 active picture, 1 vertical-blanking lines, 2 everything |
| delayCfg | input | DLY_W | Number of samples skipped after a frame start |
| ovfClear | input | 1 | Clears the overflow flag |
| outReady | input | 1 | Write port can accept a sample |
| outData | output | DATA_W | Forwarded sample |
| outValid | output | 1 | `outData` is a forwarded sample |
| overflow | output | 1 | Sticky: a forwarded sample met `outReady`=0 |

## Verification
The stream is built from lines with both blanking kinds, carrying distinct values in both bytes. Each capture mode is run over a full two-field frame, so a wrong V/H tag or a leak of code words shows up as a data mismatch.

One frame uses a non-zero delay in the keep-everything mode, which exposes off-by-one errors in the skip count. A configuration change halfway through that frame separates latching at the frame boundary from latching immediately.

Holding the stream before the first frame start shows whether the block forwards anything unsynchronised. Dropping `outReady` once over a line that forwards nothing and once over active picture tells a real loss apart from an idle stall.

// File: rtl/vbf_pkg.sv
package vbf_pkg;
  localparam int PRE_LEN = 3;
  localparam int SYNC_W  = 8;
  localparam int F_BIT   = 6;
  localparam int V_BIT   = 5;
  localparam int H_BIT   = 4;

  typedef enum logic [1:0] {
    CAP_ACTIVE     = 2'd0,
    CAP_VBLANK     = 2'd1,
    CAP_ENTIRE     = 2'd2,
    CAP_ACTIVE_ALT = 2'd3
  } capMode_e;

  // control -> datapath: line state applied to incoming plain samples
  typedef struct packed {
    logic lineV;
    logic lineH;
  } lineStb_t;

  // datapath -> control: reference seen at the input this cycle
  typedef struct packed {
    logic hit;
    logic fld;
    logic vert;
    logic horz;
  } refStb_t;

  // datapath -> control: tags of the sample at the pipeline tail
  typedef struct packed {
    logic code;
    logic vb;
    logic hb;
  } tailTag_t;

  function automatic logic [SYNC_W-1:0] preByte(input int idx);
    return (idx == 0) ? {SYNC_W{1'b1}} : {SYNC_W{1'b0}};
  endfunction
endpackage

// File: rtl/vbf_datapath.sv
module vbf_datapath
  import vbf_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] pixData,
  input  lineStb_t          lineStb,
  output refStb_t           refStb,
  output tailTag_t          tailTag,
  output logic [DATA_W-1:0] tailData
);
  localparam int STAGES = PRE_LEN + 1;

  logic [DATA_W-1:0]  stData [STAGES];
  logic [STAGES-1:0]  stCode;
  logic [STAGES-1:0]  stVb;
  logic [STAGES-1:0]  stHb;
  logic [PRE_LEN-1:0] preMatch;

  // stage g holds preamble word PRE_LEN-1-g when a reference completes
  for (genvar g = 0; g < PRE_LEN; g++) begin : g_match
    assign preMatch[g] = (stData[g][SYNC_W-1:0] == preByte(PRE_LEN - 1 - g));
  end

  assign refStb.hit  = &preMatch;
  assign refStb.fld  = pixData[F_BIT];
  assign refStb.vert = pixData[V_BIT];
  assign refStb.horz = pixData[H_BIT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < STAGES; k++) begin
        stData[k] <= '0;
      end
      stCode <= '0;
      stVb   <= '0;
      stHb   <= '0;
    end else begin
      stData[0] <= pixData;
      stCode[0] <= refStb.hit;
      stVb[0]   <= refStb.hit ? refStb.vert : lineStb.lineV;
      stHb[0]   <= refStb.hit ? refStb.horz : lineStb.lineH;
      for (int k = 1; k < STAGES; k++) begin
        stData[k] <= stData[k-1];
        stCode[k] <= stCode[k-1] | refStb.hit;
        stVb[k]   <= refStb.hit ? refStb.vert : stVb[k-1];
        stHb[k]   <= refStb.hit ? refStb.horz : stHb[k-1];
      end
    end
  end

  assign tailData     = stData[STAGES-1];
  assign tailTag.code = stCode[STAGES-1];
  assign tailTag.vb   = stVb[STAGES-1];
  assign tailTag.hb   = stHb[STAGES-1];
endmodule

// File: rtl/vbf_ctrl.sv
module vbf_ctrl
  import vbf_pkg::*;
#(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       modeSel,
  input  logic [DLY_W-1:0] delayCfg,
  input  logic             outReady,
  input  logic             ovfClear,
  input  refStb_t          refStb,
  input  tailTag_t         tailTag,
  output lineStb_t         lineStb,
  output logic             frameStart,
  output logic             fwd,
  output logic             overflow
);
  logic             curF;
  logic             curV;
  logic             curH;
  logic             armed;
  capMode_e         capMode;
  logic [DLY_W-1:0] skipCnt;
  logic             modePass;

  assign lineStb.lineV = curV;
  assign lineStb.lineH = curH;

  assign frameStart = refStb.hit && !refStb.fld && refStb.vert && !(!curF && curV);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curF <= 1'b1;
      curV <= 1'b0;
      curH <= 1'b1;
    end else if (refStb.hit) begin
      curF <= refStb.fld;
      curV <= refStb.vert;
      curH <= refStb.horz;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed   <= 1'b0;
      capMode <= CAP_ACTIVE;
      skipCnt <= '0;
    end else if (frameStart) begin
      armed   <= 1'b1;
      capMode <= capMode_e'(modeSel);
      skipCnt <= delayCfg;
    end else if (skipCnt != '0) begin
      skipCnt <= skipCnt - 1'b1;
    end
  end

  always_comb begin
    case (capMode)
      CAP_VBLANK: modePass = tailTag.vb;
      CAP_ENTIRE: modePass = 1'b1;
      default:    modePass = !tailTag.code && !tailTag.vb && !tailTag.hb;
    endcase
  end

  assign fwd = armed && (skipCnt == '0) && modePass;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      overflow <= 1'b0;
    end else if (fwd && !outReady) begin
      overflow <= 1'b1;
    end else if (ovfClear) begin
      overflow <= 1'b0;
    end
  end
endmodule

// File: rtl/video_blank_filter.sv
module video_blank_filter
  import vbf_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DLY_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] pixData,
  input  logic [1:0]        modeSel,
  input  logic [DLY_W-1:0]  delayCfg,
  input  logic              ovfClear,
  input  logic              outReady,
  output logic [DATA_W-1:0] outData,
  output logic              outValid,
  output logic              overflow
);
  lineStb_t lineStb;
  refStb_t  refStb;
  tailTag_t tailTag;
  logic     frameStart;
  logic     fwd;

  vbf_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .pixData  (pixData),
    .lineStb  (lineStb),
    .refStb   (refStb),
    .tailTag  (tailTag),
    .tailData (outData)
  );

  vbf_ctrl #(.DLY_W(DLY_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .modeSel    (modeSel),
    .delayCfg   (delayCfg),
    .outReady   (outReady),
    .ovfClear   (ovfClear),
    .refStb     (refStb),
    .tailTag    (tailTag),
    .lineStb    (lineStb),
    .frameStart (frameStart),
    .fwd        (fwd),
    .overflow   (overflow)
  );

  assign outValid = fwd;
endmodule

// File: rtl/vbf_checker.sv
module vbf_checker #(
  parameter int DLY_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             outValid,
  input logic             outReady,
  input logic             overflow,
  input logic             ovfClear,
  input logic             frameStart,
  input logic [1:0]       modeSel,
  input logic [DLY_W-1:0] delayCfg,
  input logic [7:0]       outLow
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rstN |=> !outValid && !overflow);

  p_fs_delay_r8: assert property (@(posedge clk) disable iff (!rstN)
    frameStart && (delayCfg != '0) |=> !outValid);

  p_fs_entire_r7: assert property (@(posedge clk) disable iff (!rstN)
    frameStart && (delayCfg == '0) && (modeSel == 2'd2) |=> outValid && (outLow == 8'hFF));

  p_ovf_cause_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overflow) |-> $past(outValid && !outReady));

  p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    overflow && !ovfClear |=> overflow);

  p_ovf_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    ovfClear && !(outValid && !outReady) |=> !overflow);

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rstN)
    !overflow && !outValid |=> !overflow);
endmodule

bind video_blank_filter vbf_checker #(.DLY_W(DLY_W)) u_vbfChk (
  .clk        (clk),
  .rstN       (rstN),
  .outValid   (outValid),
  .outReady   (outReady),
  .overflow   (overflow),
  .ovfClear   (ovfClear),
  .frameStart (frameStart),
  .modeSel    (modeSel),
  .delayCfg   (delayCfg),
  .outLow     (outData[7:0])
);

// File: tb/video_blank_filter_bench.sv
module video_blank_filter_bench;
  localparam int DATA_W = 16;
  localparam int DLY_W  = 8;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [DATA_W-1:0] pixData = '0;
  logic [1:0]        modeSel = 2'd2;
  logic [DLY_W-1:0]  delayCfg = '0;
  logic              ovfClear = 1'b0;
  logic              outReady = 1'b1;
  logic [DATA_W-1:0] outData;
  logic              outValid;
  logic              overflow;

  video_blank_filter #(.DATA_W(DATA_W), .DLY_W(DLY_W)) u_video_blank_filter (
    .clk      (clk),
    .rstN     (rstN),
    .pixData  (pixData),
    .modeSel  (modeSel),
    .delayCfg (delayCfg),
    .ovfClear (ovfClear),
    .outReady (outReady),
    .outData  (outData),
    .outValid (outValid),
    .overflow (overflow)
  );

  always #4 clk = ~clk;

  typedef struct {
    logic [DATA_W-1:0] d;
    string             tag;
  } expItem_t;

  expItem_t expQ[$];
  int    checks = 0;
  int    errors = 0;
  string curTag = "R1";
  bit    monOn = 1'b1;
  bit    clrReq = 1'b0;
  int    lineCnt = 0;
  int    mdlArmed = 0;
  int    mdlMode = 0;
  int    mdlSkip = 0;
  bit    prevF = 1'b1;
  bit    prevV = 1'b0;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // drive one sample and run the reference model on it
  task automatic sendWord(input logic [DATA_W-1:0] d, input bit isCode,
                          input bit v, input bit h, input bit fs);
    bit keep;
    expItem_t it;
    @(negedge clk);
    pixData  = d;
    ovfClear = clrReq;
    clrReq   = 1'b0;
    keep = 1'b0;
    if (fs) begin
      mdlArmed = 1;
      mdlMode  = int'(modeSel);
      mdlSkip  = int'(delayCfg);
    end
    if (mdlArmed != 0) begin
      if (mdlSkip > 0) begin
        mdlSkip--;
      end else begin
        case (mdlMode)
          1:       keep = v;
          2:       keep = 1'b1;
          default: keep = !isCode && !v && !h;
        endcase
      end
    end
    if (keep) begin
      it.d   = d;
      it.tag = curTag;
      expQ.push_back(it);
    end
  endtask

  task automatic sendCode(input bit f, input bit v, input bit h);
    bit fs;
    logic [7:0] st;
    fs = !f && v && !(!prevF && prevV);
    prevF = f;
    prevV = v;
    st = {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
    sendWord(16'h00FF, 1'b1, v, h, fs);
    sendWord(16'h0000, 1'b1, v, h, 1'b0);
    sendWord(16'h0000, 1'b1, v, h, 1'b0);
    sendWord({8'h00, st}, 1'b1, v, h, 1'b0);
  endtask

  // readyCtl: 0 none, 1 low over line body, 2 low over active picture
  task automatic sendLine(input bit f, input bit v, input int readyCtl);
    lineCnt++;
    sendCode(f, v, 1'b1);
    for (int i = 0; i < 6; i++) begin
      sendWord({8'(lineCnt), (i % 2 == 1) ? 8'h10 : 8'h80}, 1'b0, v, 1'b1, 1'b0);
      if (readyCtl == 1 && i == 0) outReady = 1'b0;
    end
    sendCode(f, v, 1'b0);
    if (readyCtl == 2) outReady = 1'b0;
    for (int i = 0; i < 8; i++) begin
      sendWord({8'(lineCnt), 8'h20 + 8'(i)}, 1'b0, v, 1'b0, 1'b0);
    end
    outReady = 1'b1;
  endtask

  task automatic sendField(input bit f);
    for (int i = 0; i < 2; i++) sendLine(f, 1'b1, 0);
    for (int i = 0; i < 3; i++) sendLine(f, 1'b0, 0);
  endtask

  // scoreboard monitor (R12 order and value)
  always @(negedge clk) begin
    expItem_t e;
    if (monOn && rstN && outValid) begin
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL %s unexpected output: actual %0h expected none", curTag, outData);
      end else begin
        e = expQ.pop_front();
        if (outData !== e.d) begin
          errors++;
          $display("FAIL %s R12 output word: actual %0h expected %0h", e.tag, outData, e.d);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(outValid == 1'b0, "R1", "outValid in reset", int'(outValid), 0);
    check(overflow == 1'b0, "R1", "overflow in reset", int'(overflow), 0);
    @(negedge clk);
    rstN = 1'b1;

    // R1: active lines before any frame start forward nothing
    curTag = "R1";
    for (int i = 0; i < 3; i++) sendLine(1'b1, 1'b0, 0);
    check(expQ.size() == 0, "R1", "expected items before sync", expQ.size(), 0);

    // R2 R3 R4 R7: whole frame in keep-everything mode
    curTag = "R2 R3 R4 R7";
    sendField(1'b0);
    sendField(1'b1);

    // R8 R11: delay 5 in keep-everything mode, config changed mid-frame
    delayCfg = 8'd5;
    curTag = "R8 R11";
    sendField(1'b0);
    modeSel  = 2'd0;
    delayCfg = 8'd0;
    sendField(1'b1);

    // R5 with R9 R10 overflow handling
    curTag = "R5";
    sendField(1'b0);
    sendLine(1'b1, 1'b1, 1);
    check(overflow == 1'b0, "R10", "overflow after idle stall", int'(overflow), 0);
    sendLine(1'b1, 1'b1, 0);
    sendLine(1'b1, 1'b0, 2);
    check(overflow == 1'b1, "R9", "overflow after lost samples", int'(overflow), 1);
    sendLine(1'b1, 1'b0, 0);
    check(overflow == 1'b1, "R9", "overflow sticky", int'(overflow), 1);
    clrReq = 1'b1;
    sendLine(1'b1, 1'b0, 0);
    check(overflow == 1'b0, "R9", "overflow after clear", int'(overflow), 0);

    // R6: vertical-blanking lines only
    modeSel = 2'd1;
    curTag = "R6";
    sendField(1'b0);
    sendField(1'b1);

    // R5 R8: alternate active code with a delay
    modeSel  = 2'd3;
    delayCfg = 8'd2;
    curTag = "R5 R8";
    sendField(1'b0);
    sendField(1'b1);
    for (int i = 0; i < 6; i++) sendWord(16'h0133, 1'b0, 1'b0, 1'b0, 1'b0);

    repeat (4) @(negedge clk);
    #1;
    check(expQ.size() == 0, "R5 R6 R7 R8", "items never produced", expQ.size(), 0);
    check(overflow == 1'b0, "R10", "overflow at end", int'(overflow), 0);
    monOn = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule